// File: doc/BRIEF.md
# Serial bank register loader

This block is the write side of a cartridge banking controller. A processor can only reach it through byte writes into the upper half of its address space, and each byte carries one useful data bit. Five such writes are gathered, lowest bit first, into a 5-bit word. The fifth write also selects which of four configuration registers receives that word: the mode/control register, either of two pattern-table bank selects, or the program bank select. A write whose bit 7 is set is a restart command. It discards any partly gathered word and forces both program banking mode bits of the control register high.

The four registers feed an address translator outside this block. Each time a word is committed, the block raises a one-cycle pulse together with the index of the register that was written. Downstream logic can use the pulse to refresh its mappings.

Top module: `serial_bank_loader`

## Requirements
- R1: After synchronous reset, the control output is 0x0C, both pattern bank outputs and the program bank output are 0, and the commit pulse is low.
- R2: A cycle where the write strobe is low, or the CPU address bit 15 input is low, changes no register and raises no commit pulse.
- R3: A qualified write with data bit 7 set ORs 0x0C into control, so bits 3:2 become 1 and bits 4, 1 and 0 keep their values. It also discards a partly gathered word, so the next five writes form a fresh value.
- R4: The serial bit is data bit 0. The first write of a group supplies value bit 0 and the fifth supplies value bit 4. Data bits 6:1 have no effect.
- R5: Only the address select (CPU address bits 14:13) present on the fifth write picks the destination: 0 is control, 1 is pattern bank 0, 2 is pattern bank 1 and 3 is program bank. Address selects on writes one to four are ignored.
- R6: The program bank register stores bits 3:0 of the committed value. Control and both pattern bank registers store all five bits.
- R7: After a commit, gathering restarts, so back-to-back groups of five writes each commit their own value.
- R8: In the cycle after the fifth write, the commit pulse is high for exactly one cycle and the commit index shows the destination code from R5.
- R9: A write that has bit 7 set and bit 0 set acts only as a restart command. No bit is gathered from it.
- R10: One to four gathered writes change no register and raise no commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| cpu_a15 | input | 1 | Processor address bit 15; writes count only when it is high |
| addr_sel | input | 2 | Processor address bits 14:13, the destination select |
| wr_data | input | 8 | Written byte; bit 7 is the restart command, bit 0 is the serial bit |
| ctrl_q | output | 5 | Control register |
| patt0_q | output | 5 | Pattern bank 0 select |
| patt1_q | output | 5 | Pattern bank 1 select |
| prog_q | output | 4 | Program bank select |
| commit_pulse | output | 1 | High for one cycle after a word is committed |
| commit_idx | output | 2 | Destination code of the latest commit |

## Verification
A vector table loads all four destinations twice with distinct 5-bit words. The writes before the fifth carry the inverse address select, so a design that latches the destination early is caught. Asymmetric words such as 0x01 against 0x10, and 0x1B written to the program bank, expose a reversed bit order and a program bank that keeps a fifth bit. Noise on data bits 6:1 shows that only bit 0 is gathered. Directed sequences then interrupt a partial word with a restart command (plain and with bit 0 set), stop after four writes, and drive writes with the strobe or address bit 15 low. These show when commits are allowed, how the restart command takes priority, and how writes are qualified.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    localparam int DATA_W    = 8;
    localparam int SHIFT_LEN = 5;
    localparam int VAL_W     = SHIFT_LEN;
    localparam int CNT_W     = $clog2(SHIFT_LEN + 1);
    localparam int PROG_W    = 4;
    localparam int CMD_BIT   = 7;
    localparam int SER_BIT   = 0;

    typedef logic [VAL_W-1:0] val_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam val_t CTRL_RESET      = val_t'(5'h0C);
    localparam val_t CTRL_FORCE_MASK = val_t'(5'h0C);

    typedef enum logic [1:0] {
        DEST_CTRL  = 2'd0,
        DEST_PATT0 = 2'd1,
        DEST_PATT1 = 2'd2,
        DEST_PROG  = 2'd3
    } dest_e;

    typedef struct packed {
        val_t              ctrl;
        val_t              patt0;
        val_t              patt1;
        logic [PROG_W-1:0] prog;
    } bank_regs_t;

    // Put one serial bit into the gathered word at the position given by the count
    function automatic val_t merge_bit(val_t acc, cnt_t pos, logic b);
        val_t one_hot;
        one_hot = val_t'(1) << pos;
        return b ? (acc | one_hot) : acc;
    endfunction

endpackage

// File: rtl/sbl_qualify.sv
module sbl_qualify (
    input  logic wr_en,
    input  logic cpu_a15,
    output logic wr_q
);
    // Only writes to the upper half of the processor space reach the loader
    always_comb wr_q = wr_en & cpu_a15;
endmodule

// File: rtl/sbl_shifter.sv
module sbl_shifter
    import sbl_pkg::*;
#(
    parameter int CMD_POS = CMD_BIT,
    parameter int SER_POS = SER_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_q,
    input  logic [DATA_W-1:0] data,
    output logic              rst_cmd,
    output logic              commit_now,
    output val_t              full_val
);
    localparam cnt_t LAST = cnt_t'(SHIFT_LEN - 1);

    cnt_t cnt;
    val_t acc;
    logic shift_en;

    // Bits other than the command and serial positions are deliberately ignored
    logic unused_data_bits;
    always_comb unused_data_bits = ^data;

    always_comb begin
        rst_cmd    = wr_q &  data[CMD_POS];
        shift_en   = wr_q & ~data[CMD_POS];
        commit_now = shift_en && (cnt == LAST);
        full_val   = merge_bit(acc, cnt, data[SER_POS]);
    end

    always_ff @(posedge clk) begin
        if (rst || rst_cmd || commit_now) begin
            acc <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            acc <= full_val;
            cnt <= cnt + cnt_t'(1);
        end
    end

    // R10: the count never reaches the group length
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt < cnt_t'(SHIFT_LEN));

    // R7: gathering restarts after a commit
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        commit_now |=> (cnt == '0) && (acc == '0));

    // R3: a restart command discards a partial word
    p_cmd_clear_r3: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> (cnt == '0) && (acc == '0));

endmodule

// File: rtl/sbl_regfile.sv
module sbl_regfile
    import sbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_cmd,
    input  logic       commit_now,
    input  dest_e      dest,
    input  val_t       full_val,
    output bank_regs_t regs,
    output logic       pulse,
    output dest_e      pulse_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs.ctrl  <= CTRL_RESET;
            regs.patt0 <= '0;
            regs.patt1 <= '0;
            regs.prog  <= '0;
        end else if (rst_cmd) begin
            regs.ctrl <= regs.ctrl | CTRL_FORCE_MASK;
        end else if (commit_now) begin
            case (dest)
                DEST_CTRL:  regs.ctrl  <= full_val;
                DEST_PATT0: regs.patt0 <= full_val;
                DEST_PATT1: regs.patt1 <= full_val;
                DEST_PROG:  regs.prog  <= full_val[PROG_W-1:0];
                default:    regs.ctrl  <= regs.ctrl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse     <= 1'b0;
            pulse_idx <= DEST_CTRL;
        end else begin
            pulse <= commit_now;
            if (commit_now) pulse_idx <= dest;
        end
    end

    // R3: restart command forces the mode bits and keeps the rest
    p_force_mode_r3: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> (regs.ctrl[3:2] == 2'b11)
                 && (regs.ctrl[4] == $past(regs.ctrl[4]))
                 && (regs.ctrl[1:0] == $past(regs.ctrl[1:0])));

    // R8: commit is announced in the following cycle with its destination
    p_pulse_idx_r8: assert property (@(posedge clk) disable iff (rst)
        commit_now |=> pulse && (pulse_idx == $past(dest)));

    // R8: the pulse lasts a single cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R6: program bank keeps the low four bits
    p_prog_trunc_r6: assert property (@(posedge clk) disable iff (rst)
        (commit_now && dest == DEST_PROG) |=> regs.prog == $past(full_val[PROG_W-1:0]));

endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader
    import sbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              cpu_a15,
    input  logic [1:0]        addr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VAL_W-1:0]  ctrl_q,
    output logic [VAL_W-1:0]  patt0_q,
    output logic [VAL_W-1:0]  patt1_q,
    output logic [PROG_W-1:0] prog_q,
    output logic              commit_pulse,
    output logic [1:0]        commit_idx
);
    logic       wr_q;
    logic       rst_cmd;
    logic       commit_now;
    val_t       full_val;
    bank_regs_t regs;
    dest_e      pulse_idx;
    dest_e      dest;

    always_comb dest = dest_e'(addr_sel);

    sbl_qualify u_qualify (
        .wr_en   (wr_en),
        .cpu_a15 (cpu_a15),
        .wr_q    (wr_q)
    );

    sbl_shifter #(
        .CMD_POS (CMD_BIT),
        .SER_POS (SER_BIT)
    ) u_shifter (
        .clk        (clk),
        .rst        (rst),
        .wr_q       (wr_q),
        .data       (wr_data),
        .rst_cmd    (rst_cmd),
        .commit_now (commit_now),
        .full_val   (full_val)
    );

    sbl_regfile u_regfile (
        .clk        (clk),
        .rst        (rst),
        .rst_cmd    (rst_cmd),
        .commit_now (commit_now),
        .dest       (dest),
        .full_val   (full_val),
        .regs       (regs),
        .pulse      (commit_pulse),
        .pulse_idx  (pulse_idx)
    );

    always_comb begin
        ctrl_q     = regs.ctrl;
        patt0_q    = regs.patt0;
        patt1_q    = regs.patt1;
        prog_q     = regs.prog;
        commit_idx = pulse_idx;
    end

    // R2: unqualified cycles leave every register alone and raise no pulse
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && cpu_a15) |=> $stable(regs) && !commit_pulse);

endmodule

// File: tb/serial_bank_loader_test.sv
module serial_bank_loader_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       cpu_a15 = 1'b0;
    logic [1:0] addr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [4:0] ctrl_q, patt0_q, patt1_q;
    logic [3:0] prog_q;
    logic       commit_pulse;
    logic [1:0] commit_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model, built from the requirements
    logic [4:0] m_ctrl, m_p0, m_p1;
    logic [3:0] m_prog;

    always #4 clk = ~clk;

    serial_bank_loader uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .cpu_a15(cpu_a15),
        .addr_sel(addr_sel), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .patt0_q(patt0_q), .patt1_q(patt1_q), .prog_q(prog_q),
        .commit_pulse(commit_pulse), .commit_idx(commit_idx)
    );

    // {destination[1:0], value[4:0]}
    localparam logic [6:0] VECS [8] = '{
        {2'd0, 5'h13}, {2'd1, 5'h1F}, {2'd2, 5'h01}, {2'd3, 5'h1B},
        {2'd1, 5'h10}, {2'd2, 5'h15}, {2'd0, 5'h00}, {2'd3, 5'h16}
    };

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(string tag);
        chk({tag, " ctrl"},  ctrl_q,  m_ctrl);
        chk({tag, " patt0"}, patt0_q, m_p0);
        chk({tag, " patt1"}, patt1_q, m_p1);
        chk({tag, " prog"},  prog_q,  m_prog);
    endtask

    task automatic model_reset();
        m_ctrl = 5'h0C; m_p0 = '0; m_p1 = '0; m_prog = '0;
    endtask

    task automatic model_commit(logic [1:0] sel, logic [4:0] v);
        case (sel)
            2'd0: m_ctrl = v;
            2'd1: m_p0   = v;
            2'd2: m_p1   = v;
            default: m_prog = v[3:0];
        endcase
    endtask

    // one write, inputs driven at the falling edge, released after the rising edge
    task automatic wr(logic en, logic a15, logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        wr_en = en; cpu_a15 = a15; addr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; cpu_a15 = 1'b0; wr_data = 8'd0;
    endtask

    // five serial writes; earlier writes carry another select, data bits 6:1 carry noise
    task automatic load(logic [1:0] sel, logic [4:0] v, logic [1:0] early_sel);
        for (int i = 0; i < 5; i++)
            wr(1'b1, 1'b1, (i == 4) ? sel : early_sel, {1'b0, 6'b101101, v[i]});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        idle(3);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1: reset state
        check_regs("R1 reset");
        chk("R1 pulse", commit_pulse, 0);

        // Table walk: R4 R5 R6 R7 R8
        for (int k = 0; k < 8; k++) begin
            logic [1:0] sel;
            logic [4:0] v;
            sel = VECS[k][6:5];
            v   = VECS[k][4:0];
            load(sel, v, ~sel);
            chk("R8 pulse", commit_pulse, 1);
            chk("R8 idx", commit_idx, sel);
            model_commit(sel, v);
            check_regs("R5 R4 R7 table");
            if (sel == 2'd3) chk("R6 prog", prog_q, v[3:0]);
            idle(1);
            chk("R8 pulse drop", commit_pulse, 0);
        end

        // R2: strobe low / address bit 15 low
        for (int i = 0; i < 5; i++) wr(1'b1, 1'b0, 2'd1, 8'h01);
        chk("R2 a15 low pulse", commit_pulse, 0);
        check_regs("R2 a15 low");
        for (int i = 0; i < 5; i++) wr(1'b0, 1'b1, 2'd2, 8'h81);
        chk("R2 strobe low pulse", commit_pulse, 0);
        check_regs("R2 strobe low");

        // R3: restart command on a control value with bits 4,1,0 set
        load(2'd0, 5'h11, 2'd3);
        model_commit(2'd0, 5'h11);
        check_regs("R3 setup");
        wr(1'b1, 1'b1, 2'd2, 8'h80);
        m_ctrl = m_ctrl | 5'h0C;
        chk("R3 force ctrl", ctrl_q, 5'h1D);
        chk("R3 no pulse", commit_pulse, 0);
        check_regs("R3 force");

        // R3: restart command discards two gathered bits
        wr(1'b1, 1'b1, 2'd2, 8'h01);
        wr(1'b1, 1'b1, 2'd2, 8'h01);
        wr(1'b1, 1'b1, 2'd2, 8'h80);
        load(2'd2, 5'h04, 2'd0);
        model_commit(2'd2, 5'h04);
        chk("R3 fresh value", patt1_q, 5'h04);
        check_regs("R3 discard");

        // R9: restart with bit 0 set gathers nothing
        wr(1'b1, 1'b1, 2'd1, 8'h81);
        load(2'd1, 5'h0A, 2'd2);
        model_commit(2'd1, 5'h0A);
        chk("R9 value", patt0_q, 5'h0A);
        check_regs("R9");

        // R10: four writes commit nothing
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, 1'b1, 2'd1, 8'h01);
            chk("R10 no pulse", commit_pulse, 0);
        end
        check_regs("R10 partial");
        wr(1'b1, 1'b1, 2'd1, 8'h00);
        model_commit(2'd1, 5'h0F);
        chk("R10 fifth commits", patt0_q, 5'h0F);
        chk("R10 idx", commit_idx, 1);

        // R1: reset again after activity
        @(negedge clk) rst = 1'b1;
        idle(2);
        @(negedge clk) rst = 1'b0;
        #1;
        model_reset();
        check_regs("R1 re-reset");
        chk("R1 re-reset pulse", commit_pulse, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule